// File: doc/BRIEF.md
# Interleaved Banked Memory Front End

This block sits in front of a word-wide main memory that is split into several independent banks and shared by a small set of requesting ports. Each port presents a read or write request with a program-relative address, a relocation base and a field limit. The block adds the base to the address and rejects any program address at or beyond the limit, or any relocated address beyond the installed memory. It then picks the bank from the low bits of the relocated address and the word inside that bank from the bits above them, so consecutive addresses fall in consecutive banks.

A bank that has just been accessed stays busy for a fixed number of cycles. A request to a busy bank stays pending, with its valid held, until the bank frees up. At most one access is started per cycle. It goes to the highest-priority port whose request is legal and whose bank is idle, so a request stuck on a busy bank never holds back another port that targets a free bank. Port 0 is the processor port and has the highest priority. Read data comes back a fixed number of cycles after the grant, together with the index of the port that asked for it. The storage itself is a behavioural array.

Top module: `banked_mem_front`

## Requirements
- R1: While reset is asserted and in the cycle after it, no grant and no read-return valid are asserted, and every bank is idle: a legal request made just after reset is granted in its first cycle.
- R2: The relocated address is program address plus base, taken modulo 2^ADDR_W. With the defaults (3 bank bits, 4 offset bits), relocated bits [2:0] select the bank and bits [6:3] select the word in the bank. A word written through one base reads back through another base that reaches the same relocated address.
- R3: A valid request whose program address is greater than or equal to its limit, or whose relocated address is 2^(BANK_BITS+OFF_BITS) or more, asserts that port's fault output in the same cycle. It is not granted, and it leaves memory unchanged.
- R4: After a grant to a bank, that bank accepts no new grant for BANK_CYCLE-1 cycles (default 10-cycle bank cycle). A request held on that bank is granted exactly BANK_CYCLE cycles after the previous grant, provided no higher-priority port competes.
- R5: At most one port is granted in any cycle.
- R6: Among ports that are valid, not faulting and targeting an idle bank, the port with the lowest index is granted. Port 0 has the highest priority.
- R7: A request to a busy bank does not block a lower-priority port whose request targets an idle bank. That port is granted in the same cycle.
- R8: A granted read returns its data RD_LAT cycles after the grant cycle (default 2), with rd_valid high for one cycle and rd_port equal to the index of the granted port. Writes produce no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Request valid per port, held until grant or fault |
| req_we | input | NP | 1 = write, 0 = read, per port |
| req_addr | input | NP*ADDR_W | Program address per port, port p in slice p |
| req_base | input | NP*ADDR_W | Relocation base per port |
| req_limit | input | NP*ADDR_W | Field limit per port (exclusive) |
| req_wdata | input | NP*WORD_W | Write data per port |
| req_grant | output | NP | Request accepted this cycle (one-hot or zero) |
| req_fault | output | NP | Request rejected by the bounds check this cycle |
| rd_valid | output | 1 | Read data return valid |
| rd_port | output | PID_W | Port that issued the returning read |
| rd_data | output | WORD_W | Returned read data |

## Verification
The assertions assume that a requester keeps valid and its address, base, limit and data steady until it sees a grant or a fault, and that it drops the request in the cycle after. The bench keeps a pending record for each port and changes it only after a grant or a fault. It mixes random bases, limits and addresses, some of which deliberately overrun the limit or the installed memory, with directed cases for priority, bank conflicts and relocation. All reads target words that a prefill pass has written, so every returned value is known to the bench's own memory model.

// File: rtl/mem_front_pkg.sv
package mem_front_pkg;
  localparam int unsigned DEF_NP         = 3;
  localparam int unsigned DEF_ADDR_W     = 18;
  localparam int unsigned DEF_WORD_W     = 60;
  localparam int unsigned DEF_BANK_BITS  = 3;
  localparam int unsigned DEF_OFF_BITS   = 4;
  localparam int unsigned DEF_BANK_CYCLE = 10;
  localparam int unsigned DEF_RD_LAT     = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/front_addr_check.sv
module front_addr_check #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned BANK_BITS = 3,
  parameter int unsigned OFF_BITS  = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    base,
  input  logic [ADDR_W-1:0]    limit,
  output logic                 fault,
  output logic [BANK_BITS-1:0] bank,
  output logic [OFF_BITS-1:0]  offset
);
  localparam int unsigned MEM_BITS = BANK_BITS + OFF_BITS;

  function automatic logic [ADDR_W:0] relocate(input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic beyond_mem(input logic [ADDR_W-1:0] p);
    return (p >> MEM_BITS) != '0;
  endfunction

  logic [ADDR_W:0]   sum;
  logic [ADDR_W-1:0] phys;

  assign sum    = relocate(addr, base);
  assign phys   = sum[ADDR_W-1:0];
  assign bank   = phys[BANK_BITS-1:0];
  assign offset = phys[BANK_BITS +: OFF_BITS];
  // the carry out of the add is dropped: relocation wraps modulo 2^ADDR_W
  assign fault  = (addr >= limit) || beyond_mem(phys);

  // R3: a relocated address past the installed words is always rejected
  always_comb begin
    a_r3_range_fault: assert (!(beyond_mem(phys)) || fault);
  end
endmodule

// File: rtl/front_bank_timer.sv
module front_bank_timer #(
  parameter int unsigned CYCLE = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = (CYCLE > 1) ? $clog2(CYCLE) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLE - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R4: an access is only started on an idle bank
  a_r4_start_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  generate
    if (CYCLE > 1) begin : g_busy_chk
      // R4: the bank is busy right after an access starts
      a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end
  endgenerate
endmodule

// File: rtl/front_prio_pick.sv
module front_prio_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end

  // R5: one access per cycle
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6: a grant only goes to an eligible port
  a_r6_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0);
endmodule

// File: rtl/front_read_pipe.sv
module front_read_pipe #(
  parameter int unsigned LAT    = 2,
  parameter int unsigned N      = 3,
  parameter int unsigned IW     = 2,
  parameter int unsigned WORD_W = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [IW-1:0]     in_port,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_v,
  output logic [IW-1:0]     out_port,
  output logic [WORD_W-1:0] out_data
);
  logic              v_q [LAT];
  logic [IW-1:0]     p_q [LAT];
  logic [WORD_W-1:0] d_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    p_q[0] <= in_port;
    d_q[0] <= in_data;
    for (int i = 1; i < LAT; i++) begin
      p_q[i] <= p_q[i-1];
      d_q[i] <= d_q[i-1];
    end
  end

  assign out_v    = v_q[LAT-1];
  assign out_port = p_q[LAT-1];
  assign out_data = d_q[LAT-1];

  // R8: returned tag names an existing port
  a_r8_port_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> (int'(out_port) < N));
endmodule

// File: rtl/banked_mem_front.sv
module banked_mem_front
  import mem_front_pkg::*;
#(
  parameter int unsigned NP         = DEF_NP,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned BANK_BITS  = DEF_BANK_BITS,
  parameter int unsigned OFF_BITS   = DEF_OFF_BITS,
  parameter int unsigned BANK_CYCLE = DEF_BANK_CYCLE,
  parameter int unsigned RD_LAT     = DEF_RD_LAT,
  parameter int unsigned PID_W      = idx_width(NP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_valid,
  input  logic [NP-1:0]        req_we,
  input  logic [NP*ADDR_W-1:0] req_addr,
  input  logic [NP*ADDR_W-1:0] req_base,
  input  logic [NP*ADDR_W-1:0] req_limit,
  input  logic [NP*WORD_W-1:0] req_wdata,
  output logic [NP-1:0]        req_grant,
  output logic [NP-1:0]        req_fault,
  output logic                 rd_valid,
  output logic [PID_W-1:0]     rd_port,
  output logic [WORD_W-1:0]    rd_data
);
  localparam int unsigned NBANKS = 1 << BANK_BITS;
  localparam int unsigned DEPTH  = 1 << OFF_BITS;

  logic [NP-1:0]        fault_w;
  logic [BANK_BITS-1:0] bank_w [NP];
  logic [OFF_BITS-1:0]  off_w  [NP];
  logic [NP-1:0]        elig;
  logic [NBANKS-1:0]    bank_busy;
  logic [NBANKS-1:0]    bank_start;

  logic                 gnt_any;
  logic [PID_W-1:0]     gnt_idx;
  logic [BANK_BITS-1:0] gnt_bank;
  logic [OFF_BITS-1:0]  gnt_off;
  logic                 gnt_we;
  logic [WORD_W-1:0]    gnt_wdata;
  logic [WORD_W-1:0]    gnt_rdata;

  logic [WORD_W-1:0] mem [NBANKS][DEPTH];

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      front_addr_check #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .OFF_BITS(OFF_BITS)
      ) u_chk (
        .addr  (req_addr [p*ADDR_W +: ADDR_W]),
        .base  (req_base [p*ADDR_W +: ADDR_W]),
        .limit (req_limit[p*ADDR_W +: ADDR_W]),
        .fault (fault_w[p]),
        .bank  (bank_w[p]),
        .offset(off_w[p])
      );
      assign elig[p] = req_valid[p] && !fault_w[p] && !bank_busy[bank_w[p]];
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      assign bank_start[b] = gnt_any && (gnt_bank == BANK_BITS'(b));
      front_bank_timer #(.CYCLE(BANK_CYCLE)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(bank_start[b]),
        .busy (bank_busy[b])
      );
    end
  endgenerate

  assign req_fault = req_valid & fault_w;

  front_prio_pick #(.N(NP), .IW(PID_W)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .elig (elig),
    .grant(req_grant),
    .any  (gnt_any),
    .idx  (gnt_idx)
  );

  assign gnt_bank  = bank_w[gnt_idx];
  assign gnt_off   = off_w[gnt_idx];
  assign gnt_we    = req_we[gnt_idx];
  assign gnt_wdata = req_wdata[gnt_idx*WORD_W +: WORD_W];
  assign gnt_rdata = mem[gnt_bank][gnt_off];

  always_ff @(posedge clk) begin
    if (gnt_any && gnt_we) mem[gnt_bank][gnt_off] <= gnt_wdata;
  end

  front_read_pipe #(
    .LAT(RD_LAT), .N(NP), .IW(PID_W), .WORD_W(WORD_W)
  ) u_rpipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (gnt_any && !gnt_we),
    .in_port (gnt_idx),
    .in_data (gnt_rdata),
    .out_v   (rd_valid),
    .out_port(rd_port),
    .out_data(rd_data)
  );

  // R3: a rejected request is never granted in the same cycle
  a_r3_fault_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fault & req_grant) == '0);
  // R7: grants only answer live requests
  a_r7_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);
  // R4: the granted bank is the one that becomes busy next cycle
  a_r4_granted_bank_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && BANK_CYCLE > 1) |=> bank_busy[$past(gnt_bank)]);
endmodule

// File: tb/banked_mem_front_test.sv
module banked_mem_front_test;
  localparam int NP = 3, AW = 18, WW = 60, BC = 10, RL = 2, MW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] req_valid, req_we, req_grant, req_fault;
  logic [NP*AW-1:0] req_addr, req_base, req_limit;
  logic [NP*WW-1:0] req_wdata;
  logic rd_valid;
  logic [1:0] rd_port;
  logic [WW-1:0] rd_data;

  banked_mem_front uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [WW-1:0] mdl [MW];
  int bcnt [8];
  int lastg [8];
  bit ev [8]; int ep [8]; logic [WW-1:0] ed [8];
  bit pv [NP]; bit pwe [NP]; int pa [NP]; int pb [NP]; int pl [NP];
  logic [WW-1:0] pwd [NP];
  logic [NP-1:0] last_grant;
  logic [WW-1:0] last_rd;
  int gap;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit f_fault(int a, int b, int l);
    int ph = (a + b) % (1 << AW);
    return (a >= l) || (ph >= MW);
  endfunction

  function automatic int f_bank(int a, int b);
    return ((a + b) % (1 << AW)) % 8;
  endfunction

  function automatic logic [WW-1:0] rnd_word();
    return {$urandom(), $urandom()} & {WW{1'b1}};
  endfunction

  task automatic set_req(int p, bit we, int a, int b, int l, logic [WW-1:0] d);
    pv[p] = 1; pwe[p] = we; pa[p] = a; pb[p] = b; pl[p] = l; pwd[p] = d;
  endtask

  task automatic do_cycle();
    logic [NP-1:0] ef, eg;
    int slot, g;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = pv[p];
      req_we[p] = pwe[p];
      req_addr[p*AW +: AW] = AW'(pa[p]);
      req_base[p*AW +: AW] = AW'(pb[p]);
      req_limit[p*AW +: AW] = AW'(pl[p]);
      req_wdata[p*WW +: WW] = pwd[p];
    end
    #1;
    ef = '0; eg = '0; g = -1;
    for (int p = 0; p < NP; p++) begin
      if (pv[p] && f_fault(pa[p], pb[p], pl[p])) ef[p] = 1'b1;
      else if (pv[p] && bcnt[f_bank(pa[p], pb[p])] == 0 && g < 0) begin
        g = p; eg[p] = 1'b1;
      end
    end
    chk(req_fault == ef, "R3", "fault vector", longint'(req_fault), longint'(ef));
    chk(req_grant == eg, "R6", "grant vector", longint'(req_grant), longint'(eg));
    chk($countones(req_grant) <= 1, "R5", "grants per cycle",
        longint'($countones(req_grant)), 1);
    slot = cyc % 8;
    if (ev[slot]) begin
      chk(rd_valid === 1'b1 && rd_port == 2'(ep[slot]) && rd_data === ed[slot],
          "R8", "read return port/data", longint'(rd_data), longint'(ed[slot]));
    end else begin
      chk(rd_valid === 1'b0, "R8", "spurious rd_valid", longint'(rd_valid), 0);
    end
    if (rd_valid === 1'b1) last_rd = rd_data;
    ev[slot] = 0;
    last_grant = req_grant;
    for (int b = 0; b < 8; b++) if (bcnt[b] > 0) bcnt[b]--;
    if (g >= 0) begin
      int bk = f_bank(pa[g], pb[g]);
      int ph = (pa[g] + pb[g]) % (1 << AW);
      if (lastg[bk] >= 0)
        chk(cyc - lastg[bk] >= BC, "R4", "bank reuse spacing", cyc - lastg[bk], BC);
      lastg[bk] = cyc;
      bcnt[bk] = BC - 1;
      if (pwe[g]) mdl[ph] = pwd[g];
      else begin
        ev[(cyc + RL) % 8] = 1; ep[(cyc + RL) % 8] = g; ed[(cyc + RL) % 8] = mdl[ph];
      end
      pv[g] = 0;
    end
    for (int p = 0; p < NP; p++) if (ef[p]) pv[p] = 0;
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) do_cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int gcyc;
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 8; b++) begin bcnt[b] = 0; lastg[b] = -1000; ev[b] = 0; end
    for (int p = 0; p < NP; p++) pv[p] = 0;
    req_valid = '0; req_we = '0; req_addr = '0; req_base = '0; req_limit = '0;
    req_wdata = '0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(req_grant == '0 && rd_valid === 1'b0, "R1", "outputs in reset",
          longint'(req_grant), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: every bank idle right after reset
    set_req(2, 1, 5, 0, MW, rnd_word());
    do_cycle();
    chk(last_grant == 3'b100, "R1", "first request granted", longint'(last_grant), 4);

    // prefill all words through port 0
    for (int a = 0; a < MW; a++) begin
      set_req(0, 1, a, 0, MW, rnd_word());
      while (pv[0]) do_cycle();
    end
    idle(12);

    // R2: write through one base, read back through another
    set_req(1, 1, 10, 37, 50, 60'h0ABC_DEF0_1234_567);
    while (pv[1]) do_cycle();
    idle(12);
    set_req(2, 0, 40, 7, 100, '0);
    while (pv[2]) do_cycle();
    idle(RL + 1);
    chk(last_rd === 60'h0ABC_DEF0_1234_567, "R2", "relocated readback",
        longint'(last_rd), longint'(60'h0ABC_DEF0_1234_567));

    // R6: three ports to idle distinct banks
    idle(12);
    set_req(0, 0, 2, 0, MW, '0);
    set_req(1, 0, 3, 0, MW, '0);
    set_req(2, 0, 4, 0, MW, '0);
    do_cycle();
    chk(last_grant == 3'b001, "R6", "port 0 wins", longint'(last_grant), 1);
    do_cycle();
    chk(last_grant == 3'b010, "R6", "port 1 next", longint'(last_grant), 2);
    idle(12);

    // R7 and R4: busy bank does not block a free one; held request waits full cycle
    set_req(0, 1, 0, 0, MW, rnd_word());
    do_cycle();
    gcyc = cyc - 1;
    set_req(0, 0, 8, 0, MW, '0);
    set_req(1, 0, 1, 0, MW, '0);
    do_cycle();
    chk(last_grant == 3'b010, "R7", "free bank proceeds", longint'(last_grant), 2);
    while (pv[0]) do_cycle();
    gap = cyc - 1 - gcyc;
    chk(gap == BC, "R4", "held request granted after bank cycle", gap, BC);
    idle(12);

    // R3: limit overrun and memory overrun; memory unchanged
    set_req(2, 1, 25, 0, 20, '1);
    do_cycle();
    chk(last_grant == '0, "R3", "limit fault not granted", longint'(last_grant), 0);
    set_req(1, 1, 10, 120, 50, '1);
    do_cycle();
    chk(last_grant == '0, "R3", "range fault not granted", longint'(last_grant), 0);
    set_req(0, 0, 25, 0, MW, '0);
    while (pv[0]) do_cycle();
    idle(RL + 1);
    chk(last_rd === mdl[25], "R3", "faulted write left word", longint'(last_rd),
        longint'(mdl[25]));

    // random mix
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NP; p++) begin
        if (!pv[p] && ($urandom() % 2) == 0) begin
          int b = $urandom() % 64;
          int l = 1 + $urandom() % 90;
          int a = $urandom() % (l + 6);
          set_req(p, bit'($urandom() % 2), a, b, l, rnd_word());
        end
      end
      do_cycle();
    end
    for (int i = 0; i < 200 && (pv[0] || pv[1] || pv[2]); i++) do_cycle();
    idle(RL + 2);
    finish_run();
  end
endmodule